// File: doc/BRIEF.md
# Fixed Power-Management Register Block

This block provides a small I/O register window for system power management. Only the low six address bits are decoded. Behind them sit a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running power-management timer. The timer advances once for every cycle in which the tick-enable input is high. That input stands for the slow timer rate, which is produced elsewhere. When a status bit of the timer, power button, global lock or RTC source is pending and its enable bit is set, the block raises a level system control interrupt.

Software writes the control register to request a sleep state. The sleep-enable bit is decoded into either a soft power-off request or a suspend. A suspend marks wake and power-button status, requests a reset and raises a suspend-to-RAM indicator. A separate 8-bit command port lets firmware switch the SCI-enable bit on or off, and can pulse an SMI output. The timer width is a parameter: 24 bits by default, with overflow boundaries at multiples of 2^(TMR_W-1). All outputs are registered. Read data is valid in the cycle after the read strobe.

Top module: `pm_fixed_regs`

## Requirements
- R1: After synchronous reset all three registers and the timer read zero, the overflow point is armed at 2^(TMR_W-1), and sci_irq, shutdown_req, reset_req, s3_ind and smi_pulse are low.
- R2: Only bus_addr[5:0] is decoded. 16-bit accesses (bus_size32=0) reach status at 0x00, enable at 0x02 and control at 0x04. A 32-bit read at 0x08 returns the timer zero-extended, so the bits above TMR_W read zero. Every other read returns zero, including a 32-bit read at 0x00 and a 16-bit read at 0x08. 32-bit writes change nothing. bus_rdata is valid one cycle after bus_rd.
- R3: The timer increments by one on each clock with tick_en high, holds otherwise, and wraps at 2^TMR_W.
- R4: A status write clears each bit written as one and leaves bits written as zero unchanged.
- R5: Status bit 0 is set on the tick that brings the timer to the armed point. Clearing bit 0 while it is set re-arms the point to the next multiple of 2^(TMR_W-1) above the current count, which is zero after a wrap.
- R6: sci_irq goes high one cycle after any of status bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC) is set together with the same enable bit. No other status bit, including wake bit 15, affects it.
- R7: A control write stores every bit except sleep-enable bit 13, which always reads back zero.
- R8: A control write with bit 13 set and sleep type bits 12:10 equal to 0 gives a one-cycle shutdown_req pulse.
- R9: A control write with bit 13 set and sleep type 1 sets status bits 15 and 8, gives a one-cycle reset_req pulse, and raises s3_ind, which stays high until reset.
- R10: Sleep types 2 to 7 with bit 13 set cause no pulse and no status change.
- R11: A command-port write of 0xF1 sets control bit 0, 0xF0 clears it, and any other value leaves it unchanged.
- R12: Every command-port write gives a one-cycle smi_pulse when smi_strap is high, and none when it is low.
- R13: A pwrbtn_evt pulse sets status bit 8 only while enable bit 8 is set. rtc_evt sets status bit 10 and gbl_evt sets status bit 5 regardless of the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_size32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | ADDR_W | Register address (low 6 bits decoded) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | RTC alarm event pulse |
| gbl_evt | input | 1 | Global-lock release event pulse |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_data | input | 8 | Command-port value |
| smi_strap | input | 1 | Enables SMI pulses on command writes |
| sci_irq | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | One-cycle soft power-off request |
| reset_req | output | 1 | One-cycle reset request on suspend |
| s3_ind | output | 1 | Suspend-to-RAM indicator |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
The bench uses a 10-bit timer so that both overflow boundaries can be reached: the mid-range one and the wrap to zero. It also re-arms once from below and once from above the half point, which tells a correct re-arm apart from one that always picks the same boundary. Status writes are made with all-zero, single-bit and all-one patterns, which separate write-one-to-clear from plain store and from ignored writes. The interrupt is tried with each source both enabled and masked, and with the wake bit pending, to show that the mask selects exactly four sources. All eight sleep types, and command values both matching and not matching the two codes, confirm that only the defined codes act.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;
  localparam int WIN_BITS = 6;
  localparam int BUS_W    = 32;
  localparam int REG_W    = 16;

  localparam logic [WIN_BITS-1:0] OFS_STS = 6'h00;
  localparam logic [WIN_BITS-1:0] OFS_EN  = 6'h02;
  localparam logic [WIN_BITS-1:0] OFS_CTL = 6'h04;
  localparam logic [WIN_BITS-1:0] OFS_TMR = 6'h08;

  localparam int B_TMR   = 0;
  localparam int B_GBL   = 5;
  localparam int B_PWR   = 8;
  localparam int B_RTC   = 10;
  localparam int B_WAKE  = 15;
  localparam int B_SCIEN = 0;
  localparam int B_SLPEN = 13;
  localparam int SLP_LO  = 10;

  localparam logic [REG_W-1:0] SCI_SRC_MASK =
    (16'h1 << B_TMR) | (16'h1 << B_GBL) | (16'h1 << B_PWR) | (16'h1 << B_RTC);

  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;

  typedef enum logic [1:0] {ACT_NONE, ACT_OFF, ACT_SUSPEND} slp_act_e;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             rearm,
  output logic [TMR_W-1:0] cnt_q,
  output logic             ovf_hit
);
  localparam int TOP = TMR_W - 1;

  logic [TMR_W-1:0] cnt_nx;
  logic             arm_hi_q;   // armed point: 1 -> half range, 0 -> zero

  assign cnt_nx  = cnt_q + 1'b1;
  assign ovf_hit = tick_en && (cnt_nx[TOP] == arm_hi_q) && (cnt_nx[TOP-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      arm_hi_q <= 1'b1;
    end else begin
      if (tick_en) cnt_q <= cnt_nx;
      if (rearm)   arm_hi_q <= ~cnt_q[TOP];
    end
  end
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             tmr_hit,
  input  logic             pwrbtn_evt,
  input  logic             rtc_evt,
  input  logic             gbl_evt,
  input  logic             wake_set,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic             sci_irq,
  output logic             rearm
);
  logic [REG_W-1:0] set_v, clr_v;

  assign rearm = wr_sts && wdata[B_TMR] && sts_q[B_TMR];

  always_comb begin
    set_v         = '0;
    set_v[B_TMR]  = tmr_hit;
    set_v[B_GBL]  = gbl_evt;
    set_v[B_RTC]  = rtc_evt;
    set_v[B_PWR]  = (pwrbtn_evt && en_q[B_PWR]) || wake_set;
    set_v[B_WAKE] = wake_set;
    clr_v         = wr_sts ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      en_q    <= '0;
      sci_irq <= 1'b0;
    end else begin
      sts_q   <= (sts_q & ~clr_v) | set_v;
      if (wr_en) en_q <= wdata;
      sci_irq <= |(sts_q & en_q & SCI_SRC_MASK);
    end
  end
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
  import pm_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_data,
  input  logic             smi_strap,
  output logic [REG_W-1:0] ctl_q,
  output logic             shutdown_req,
  output logic             reset_req,
  output logic             s3_ind,
  output logic             smi_pulse,
  output logic             wake_set
);
  slp_act_e         act;
  logic [REG_W-1:0] ctl_nx;

  always_comb begin
    act = ACT_NONE;
    if (wr_ctl && wdata[B_SLPEN]) begin
      case (wdata[SLP_LO +: 3])
        3'd0:    act = ACT_OFF;
        3'd1:    act = ACT_SUSPEND;
        default: act = ACT_NONE;
      endcase
    end
  end

  always_comb begin
    ctl_nx = ctl_q;
    if (wr_ctl) begin
      ctl_nx          = wdata;
      ctl_nx[B_SLPEN] = 1'b0;
    end
    if (cmd_wr) begin
      if (cmd_data == CMD_ON)  ctl_nx[B_SCIEN] = 1'b1;
      if (cmd_data == CMD_OFF) ctl_nx[B_SCIEN] = 1'b0;
    end
  end

  assign wake_set = (act == ACT_SUSPEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      s3_ind       <= 1'b0;
      smi_pulse    <= 1'b0;
    end else begin
      ctl_q        <= ctl_nx;
      shutdown_req <= (act == ACT_OFF);
      reset_req    <= (act == ACT_SUSPEND);
      if (act == ACT_SUSPEND) s3_ind <= 1'b1;
      smi_pulse    <= cmd_wr && smi_strap;
    end
  end
endmodule

// File: rtl/pm_fixed_regs.sv
module pm_fixed_regs
  import pm_regs_pkg::*;
#(
  parameter int TMR_W  = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_size32,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pwrbtn_evt,
  input  logic              rtc_evt,
  input  logic              gbl_evt,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_data,
  input  logic              smi_strap,
  output logic              sci_irq,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              s3_ind,
  output logic              smi_pulse
);
  logic [WIN_BITS-1:0] ofs;
  logic                wr16, wr_sts, wr_en, wr_ctl;
  logic [REG_W-1:0]    wd16, sts_q, en_q, ctl_q;
  logic [TMR_W-1:0]    cnt_q;
  logic                tmr_hit, rearm, wake_set;
  logic [BUS_W-1:0]    rd_mux;

  assign ofs    = bus_addr[WIN_BITS-1:0];
  assign wd16   = bus_wdata[REG_W-1:0];
  assign wr16   = bus_wr && !bus_size32;
  assign wr_sts = wr16 && (ofs == OFS_STS);
  assign wr_en  = wr16 && (ofs == OFS_EN);
  assign wr_ctl = wr16 && (ofs == OFS_CTL);

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rearm(rearm),
    .cnt_q(cnt_q), .ovf_hit(tmr_hit)
  );

  pm_event_regs u_evt (
    .clk(clk), .rst(rst), .wr_sts(wr_sts), .wr_en(wr_en), .wdata(wd16),
    .tmr_hit(tmr_hit), .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt),
    .gbl_evt(gbl_evt), .wake_set(wake_set), .sts_q(sts_q), .en_q(en_q),
    .sci_irq(sci_irq), .rearm(rearm)
  );

  pm_sleep_ctrl u_slp (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(wd16), .cmd_wr(cmd_wr),
    .cmd_data(cmd_data), .smi_strap(smi_strap), .ctl_q(ctl_q),
    .shutdown_req(shutdown_req), .reset_req(reset_req), .s3_ind(s3_ind),
    .smi_pulse(smi_pulse), .wake_set(wake_set)
  );

  always_comb begin
    rd_mux = '0;
    if (!bus_size32) begin
      case (ofs)
        OFS_STS: rd_mux[REG_W-1:0] = sts_q;
        OFS_EN:  rd_mux[REG_W-1:0] = en_q;
        OFS_CTL: rd_mux[REG_W-1:0] = ctl_q;
        default: rd_mux = '0;
      endcase
    end else if (ofs == OFS_TMR) begin
      rd_mux[TMR_W-1:0] = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pm_fixed_regs_chk.sv
module pm_fixed_regs_chk
  import pm_regs_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             bus_rd,
  input logic             bus_size32,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             cmd_wr,
  input logic             smi_strap,
  input logic             sci_irq,
  input logic             shutdown_req,
  input logic             reset_req,
  input logic             s3_ind,
  input logic             smi_pulse,
  input logic [REG_W-1:0] en_q,
  input logic [TMR_W-1:0] cnt
);
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt)); // R3
  AST_RD16_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_size32) |=> (bus_rdata[BUS_W-1:REG_W] == '0)); // R2
  AST_SCI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    sci_irq |-> (($past(en_q) & SCI_SRC_MASK) != '0)); // R6
  AST_SHUTDOWN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> !shutdown_req); // R8
  AST_RESET_WITH_S3: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (s3_ind && !shutdown_req)); // R9
  AST_S3_STICKY: assert property (@(posedge clk) disable iff (rst)
    s3_ind |=> s3_ind); // R9
  AST_SMI_SOURCE: assert property (@(posedge clk) disable iff (rst)
    smi_pulse |-> $past(cmd_wr && smi_strap)); // R12
endmodule

bind pm_fixed_regs pm_fixed_regs_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_rd(bus_rd),
  .bus_size32(bus_size32), .bus_rdata(bus_rdata), .cmd_wr(cmd_wr),
  .smi_strap(smi_strap), .sci_irq(sci_irq), .shutdown_req(shutdown_req),
  .reset_req(reset_req), .s3_ind(s3_ind), .smi_pulse(smi_pulse),
  .en_q(en_q), .cnt(cnt_q)
);

// File: tb/pm_fixed_regs_test.sv
module pm_fixed_regs_test;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_size32 = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwrbtn_evt = 1'b0, rtc_evt = 1'b0, gbl_evt = 1'b0;
  logic        cmd_wr = 1'b0, smi_strap = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        sci_irq, shutdown_req, reset_req, s3_ind, smi_pulse;

  int n_chk = 0, n_fail = 0;

  typedef struct { logic [31:0] exp; string req; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_prev = 1'b0;

  always #4 clk = ~clk;

  pm_fixed_regs #(.TMR_W(TW)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size32(bus_size32), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt),
    .gbl_evt(gbl_evt), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .smi_strap(smi_strap), .sci_irq(sci_irq), .shutdown_req(shutdown_req),
    .reset_req(reset_req), .s3_ind(s3_ind), .smi_pulse(smi_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) rd_prev <= bus_rd;
  always @(negedge clk) begin
    if (rd_prev) begin
      if (sb_q.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
      else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic s32);
    @(negedge clk);
    bus_wr = 1'b1; bus_size32 = s32; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_size32 = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic s32, input logic [31:0] e, input string r);
    rd_item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_size32 = s32; bus_addr = a;
    it.exp = e; it.req = r;
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0; bus_size32 = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] v);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(16'h0000, 1'b0, 32'h0, "R1 status");
    rd(16'h0002, 1'b0, 32'h0, "R1 enable");
    rd(16'h0004, 1'b0, 32'h0, "R1 control");
    rd(16'h0008, 1'b1, 32'h0, "R1 timer");
    check("R1 sci", {31'b0, sci_irq}, 32'h0);
    check("R1 s3", {31'b0, s3_ind}, 32'h0);
    // R2 decode
    rd(16'h0000, 1'b1, 32'h0, "R2 32-bit read at 0");
    rd(16'h0008, 1'b0, 32'h0, "R2 16-bit read at 8");
    wr(16'h0002, 32'h0501, 1'b0);
    rd(16'h0042, 1'b0, 32'h0501, "R2 alias of enable");
    rd(16'h0006, 1'b0, 32'h0, "R2 undecoded offset");
    wr(16'h0002, 32'hFFFF, 1'b1);
    rd(16'h0002, 1'b0, 32'h0501, "R2 32-bit write ignored");
    // R13 events, R6 masking
    @(negedge clk); rtc_evt = 1'b1; @(negedge clk); rtc_evt = 1'b0;
    @(negedge clk); check("R6 rtc enabled", {31'b0, sci_irq}, 32'h1);
    @(negedge clk); gbl_evt = 1'b1; @(negedge clk); gbl_evt = 1'b0;
    rd(16'h0000, 1'b0, 32'h0420, "R13 rtc and gbl set");
    // R4 write-one-to-clear
    wr(16'h0000, 32'h0400, 1'b0);
    rd(16'h0000, 1'b0, 32'h0020, "R4 single bit cleared");
    check("R6 gbl masked", {31'b0, sci_irq}, 32'h0);
    wr(16'h0002, 32'h0000, 1'b0);
    @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
    rd(16'h0000, 1'b0, 32'h0020, "R13 power button gated off");
    wr(16'h0002, 32'h0100, 1'b0);
    @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
    rd(16'h0000, 1'b0, 32'h0120, "R13 power button enabled");
    check("R6 power button", {31'b0, sci_irq}, 32'h1);
    wr(16'h0000, 32'h0000, 1'b0);
    rd(16'h0000, 1'b0, 32'h0120, "R4 zero write keeps bits");
    wr(16'h0000, 32'hFFFF, 1'b0);
    rd(16'h0000, 1'b0, 32'h0000, "R4 all cleared");
    // R7 / R10 control write with ignored sleep type 7
    wr(16'h0004, 32'hFFFF, 1'b0);
    check("R10 type7 no shutdown", {31'b0, shutdown_req}, 32'h0);
    check("R10 type7 no reset", {31'b0, reset_req}, 32'h0);
    rd(16'h0004, 1'b0, 32'hDFFF, "R7 sleep-enable reads zero");
    rd(16'h0000, 1'b0, 32'h0, "R10 status unchanged");
    wr(16'h0004, 32'h0000, 1'b0);
    // R11 / R12 command port
    cmd(8'hF1);
    check("R12 no smi with strap low", {31'b0, smi_pulse}, 32'h0);
    rd(16'h0004, 1'b0, 32'h0001, "R11 0xF1 sets SCI enable");
    cmd(8'h55);
    rd(16'h0004, 1'b0, 32'h0001, "R11 other value no change");
    smi_strap = 1'b1;
    cmd(8'hF0);
    check("R12 smi pulse", {31'b0, smi_pulse}, 32'h1);
    @(negedge clk);
    check("R12 smi one cycle", {31'b0, smi_pulse}, 32'h0);
    rd(16'h0004, 1'b0, 32'h0000, "R11 0xF0 clears SCI enable");
    smi_strap = 1'b0;
    // R10 types 2..7
    for (int t = 2; t < 8; t++) begin
      wr(16'h0004, 32'h2000 | (t << 10), 1'b0);
      check("R10 no shutdown", {31'b0, shutdown_req}, 32'h0);
      check("R10 no reset", {31'b0, reset_req}, 32'h0);
      rd(16'h0004, 1'b0, t << 10, "R7 type stored");
    end
    rd(16'h0000, 1'b0, 32'h0, "R10 status untouched");
    // R8 soft off
    wr(16'h0004, 32'h2000, 1'b0);
    check("R8 shutdown pulse", {31'b0, shutdown_req}, 32'h1);
    check("R8 no reset", {31'b0, reset_req}, 32'h0);
    @(negedge clk);
    check("R8 shutdown one cycle", {31'b0, shutdown_req}, 32'h0);
    check("R8 no s3", {31'b0, s3_ind}, 32'h0);
    // R9 suspend
    wr(16'h0002, 32'h8000, 1'b0);
    wr(16'h0004, 32'h2400, 1'b0);
    check("R9 reset pulse", {31'b0, reset_req}, 32'h1);
    check("R9 s3 high", {31'b0, s3_ind}, 32'h1);
    @(negedge clk);
    check("R9 reset one cycle", {31'b0, reset_req}, 32'h0);
    rd(16'h0000, 1'b0, 32'h8100, "R9 wake and power button set");
    check("R6 wake not a source", {31'b0, sci_irq}, 32'h0);
    wr(16'h0002, 32'h0100, 1'b0);
    @(negedge clk);
    check("R6 power button now enabled", {31'b0, sci_irq}, 32'h1);
    wr(16'h0000, 32'hFFFF, 1'b0);
    // R3 / R5 timer and overflow
    wr(16'h0002, 32'h0001, 1'b0);
    ticks(300);
    rd(16'h0008, 1'b1, 32'd300, "R3 timer count");
    ticks(211);
    rd(16'h0000, 1'b0, 32'h0, "R5 no overflow before half");
    check("R6 timer not pending", {31'b0, sci_irq}, 32'h0);
    ticks(1);
    rd(16'h0000, 1'b0, 32'h0001, "R5 overflow at half");
    rd(16'h0008, 1'b1, 32'd512, "R2 timer upper bits zero");
    check("R6 timer pending", {31'b0, sci_irq}, 32'h1);
    wr(16'h0000, 32'h0001, 1'b0);
    rd(16'h0000, 1'b0, 32'h0, "R4 timer bit cleared");
    ticks(511);
    rd(16'h0000, 1'b0, 32'h0, "R5 re-armed past half");
    ticks(1);
    rd(16'h0000, 1'b0, 32'h0001, "R5 overflow at wrap");
    rd(16'h0008, 1'b1, 32'd0, "R3 timer wrapped");
    wr(16'h0000, 32'h0001, 1'b0);
    ticks(511);
    rd(16'h0000, 1'b0, 32'h0, "R5 no early overflow");
    ticks(1);
    rd(16'h0000, 1'b0, 32'h0001, "R5 re-arm from low half");
    ticks(100);
    rd(16'h0008, 1'b1, 32'd612, "R3 timer after more ticks");
    // R1 reset clears sticky indicator
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 s3 cleared by reset", {31'b0, s3_ind}, 32'h0);
    rd(16'h0002, 1'b0, 32'h0, "R1 enable after reset");
    rd(16'h0008, 1'b1, 32'h0, "R1 timer after reset");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule